// File: doc/BRIEF.md
# ISA Bus Slave Address Decoder

This block sits behind the pads of a 16-bit ISA slave and turns raw host bus cycles into clean, single-cycle register-file strobes in the internal clock domain. It decodes two windows. The I/O window is always live: eight 16-bit ports spread over sixteen byte addresses, placed at a programmable base. The memory window is 4 KB, placed at a programmable base on the upper memory address bits, and only answers when the memory-mode enable is set.

The four active-low commands (I/O read, I/O write, memory read, memory write) are synchronised to the internal clock. For each period that a command is held low, the block gives one read or write strobe, provided the address hits. The strobe carries a 16-bit word offset and a byte-lane select, and a flag tells which window was hit. A data-bus drive enable is raised for an accepted read and stays up until that read command is seen high again through the synchroniser.

Top module: `isa_slave_decoder`

## Requirements
- R1: After reset, `rd_stb`, `wr_stb`, `bus_oe`, `acc_mem`, `byte_hi` and `word_off` are all 0.
- R2: An I/O read is accepted when `ior_n` is low, `aen` is low and `sa[15:4]` equals `io_base`. `rd_stb` is then high for exactly one cycle, on the third rising edge counting the first edge that samples `ior_n` low. With it, `acc_mem`=0, `word_off`=`sa[3:1]` zero-extended and `byte_hi`=`sa[0]`. These three outputs hold until the next strobe.
- R3: An I/O write (`iow_n` low) under the same address and `aen` rules gives one `wr_stb` pulse with the same timing and the same offset fields.
- R4: While `aen` is high, I/O commands produce no strobe.
- R5: An I/O address with `sa[15:4]` different from `io_base` produces no strobe.
- R6: With `mem_en` high, `memr_n` or `memw_n` low and `mem_hi` equal to `mem_base` give one `rd_stb` or `wr_stb` pulse with `acc_mem`=1, `word_off`=`sa[11:1]` and `byte_hi`=`sa[0]`. Memory cycles ignore `aen`. A different `mem_hi` gives no strobe.
- R7: With `mem_en` low, memory commands produce no strobe, while I/O decoding works regardless of `mem_en`.
- R8: A command held low for any number of cycles gives exactly one strobe. Releasing it and driving it low again gives another.
- R9: `bus_oe` rises together with an accepted read strobe and falls on the third edge after the read command is first sampled high. It is therefore high for as many cycles as the command was sampled low. It never rises for writes or for cycles that miss.
- R10: When several commands start in the same cycle and hit, only one is accepted, in the fixed order I/O read, I/O write, memory read, memory write.
- R11: `rd_stb` and `wr_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | internal clock |
| rst_n | input | 1 | asynchronous active-low reset |
| sa | input | 16 | system address; low 12 bits also index the memory window |
| mem_hi | input | 12 | upper memory address bits above the 4 KB window |
| aen | input | 1 | address enable; high blocks I/O decoding |
| ior_n | input | 1 | I/O read command, active low |
| iow_n | input | 1 | I/O write command, active low |
| memr_n | input | 1 | memory read command, active low |
| memw_n | input | 1 | memory write command, active low |
| io_base | input | 12 | I/O window base, address bits 15:4 |
| mem_base | input | 12 | memory window base, compared with `mem_hi` |
| mem_en | input | 1 | enables the memory window |
| rd_stb | output | 1 | one-cycle register read strobe |
| wr_stb | output | 1 | one-cycle register write strobe |
| acc_mem | output | 1 | last strobe came from the memory window |
| byte_hi | output | 1 | byte lane of the last strobe (`sa[0]`) |
| word_off | output | 11 | 16-bit word offset of the last strobe |
| bus_oe | output | 1 | data-bus drive enable during an accepted read |

## Verification
The hardest case to reach is two commands whose falling edges land in the same synchronised cycle. On a real bus this happens only by chance, and it is the only case that exercises the acceptance order. The bench drives the competing commands low on the same half-cycle, with both windows decoding a hit, so that both reach the edge detector together. Long holds and back-to-back re-assertion exercise the one-pulse-per-period rule. A behavioural model, built from a history of sampled commands, predicts every output on every cycle.

// File: rtl/isa_dec_pkg.sv
package isa_dec_pkg;

    localparam int MEM_WIN_BITS = 12;
    localparam int OFF_W        = MEM_WIN_BITS - 1;
    localparam int NCMD         = 4;

    localparam int CMD_IOR  = 0;
    localparam int CMD_IOW  = 1;
    localparam int CMD_MEMR = 2;
    localparam int CMD_MEMW = 3;

    typedef struct packed {
        logic             rd_stb;
        logic             wr_stb;
        logic             is_mem;
        logic             byte_hi;
        logic [OFF_W-1:0] word_off;
        logic             oe;
        logic             oe_from_mem;
        logic [NCMD-1:0]  cmd_prev_n;
    } dec_state_t;

endpackage

// File: rtl/isa_cmd_sync.sv
module isa_cmd_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_n,
    output logic [WIDTH-1:0] sync_n
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '1;
                else        stage_q[g] <= raw_n;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '1;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign sync_n = stage_q[STAGES-1];

endmodule

// File: rtl/isa_window_match.sv
module isa_window_match #(
    parameter int SA_W        = 16,
    parameter int IO_WIN_BITS = 4,
    parameter int MEM_HI_W    = 12
) (
    input  logic [SA_W-1:0]             sa,
    input  logic [MEM_HI_W-1:0]         mem_hi,
    input  logic                        aen,
    input  logic [SA_W-IO_WIN_BITS-1:0] io_base,
    input  logic [MEM_HI_W-1:0]         mem_base,
    input  logic                        mem_en,
    output logic                        io_hit,
    output logic                        mem_hit
);

    assign io_hit  = !aen && (sa[SA_W-1:IO_WIN_BITS] == io_base);
    assign mem_hit = mem_en && (mem_hi == mem_base);

endmodule

// File: rtl/isa_slave_decoder.sv
module isa_slave_decoder
    import isa_dec_pkg::*;
#(
    parameter int SA_W        = 16,
    parameter int IO_WIN_BITS = 4,
    parameter int MEM_HI_W    = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SA_W-1:0]             sa,
    input  logic [MEM_HI_W-1:0]         mem_hi,
    input  logic                        aen,
    input  logic                        ior_n,
    input  logic                        iow_n,
    input  logic                        memr_n,
    input  logic                        memw_n,
    input  logic [SA_W-IO_WIN_BITS-1:0] io_base,
    input  logic [MEM_HI_W-1:0]         mem_base,
    input  logic                        mem_en,
    output logic                        rd_stb,
    output logic                        wr_stb,
    output logic                        acc_mem,
    output logic                        byte_hi,
    output logic [OFF_W-1:0]            word_off,
    output logic                        bus_oe
);

    localparam int IO_PAD = OFF_W - (IO_WIN_BITS - 1);

    logic [NCMD-1:0] raw_n;
    logic [NCMD-1:0] sync_n;
    logic            io_hit;
    logic            mem_hit;
    dec_state_t      st_d, st_q;

    assign raw_n[CMD_IOR]  = ior_n;
    assign raw_n[CMD_IOW]  = iow_n;
    assign raw_n[CMD_MEMR] = memr_n;
    assign raw_n[CMD_MEMW] = memw_n;

    isa_cmd_sync #(
        .WIDTH  (NCMD),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_n  (raw_n),
        .sync_n (sync_n)
    );

    isa_window_match #(
        .SA_W        (SA_W),
        .IO_WIN_BITS (IO_WIN_BITS),
        .MEM_HI_W    (MEM_HI_W)
    ) i_match (
        .sa       (sa),
        .mem_hi   (mem_hi),
        .aen      (aen),
        .io_base  (io_base),
        .mem_base (mem_base),
        .mem_en   (mem_en),
        .io_hit   (io_hit),
        .mem_hit  (mem_hit)
    );

    always_comb begin
        logic [NCMD-1:0] fell;
        logic            take_ior, take_iow, take_mr, take_mw;
        logic            src_low;

        st_d = st_q;

        fell     = st_q.cmd_prev_n & ~sync_n;
        take_ior = fell[CMD_IOR] && io_hit;
        take_iow = fell[CMD_IOW] && io_hit && !take_ior;
        take_mr  = fell[CMD_MEMR] && mem_hit && !(take_ior || take_iow);
        take_mw  = fell[CMD_MEMW] && mem_hit && !(take_ior || take_iow || take_mr);

        st_d.rd_stb     = take_ior || take_mr;
        st_d.wr_stb     = take_iow || take_mw;
        st_d.cmd_prev_n = sync_n;

        if (take_ior || take_iow) begin
            st_d.is_mem   = 1'b0;
            st_d.byte_hi  = sa[0];
            st_d.word_off = {{IO_PAD{1'b0}}, sa[IO_WIN_BITS-1:1]};
        end else if (take_mr || take_mw) begin
            st_d.is_mem   = 1'b1;
            st_d.byte_hi  = sa[0];
            st_d.word_off = sa[MEM_WIN_BITS-1:1];
        end

        src_low = st_q.oe_from_mem ? !sync_n[CMD_MEMR] : !sync_n[CMD_IOR];
        if (take_ior || take_mr) begin
            st_d.oe          = 1'b1;
            st_d.oe_from_mem = take_mr;
        end else if (st_q.oe && !src_low) begin
            st_d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q            <= '0;
            st_q.cmd_prev_n <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_stb   = st_q.rd_stb;
    assign wr_stb   = st_q.wr_stb;
    assign acc_mem  = st_q.is_mem;
    assign byte_hi  = st_q.byte_hi;
    assign word_off = st_q.word_off;
    assign bus_oe   = st_q.oe;

endmodule

// File: rtl/isa_slave_decoder_chk.sv
module isa_slave_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic aen,
    input logic mem_en,
    input logic rd_stb,
    input logic wr_stb,
    input logic acc_mem,
    input logic bus_oe
);

    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!rd_stb && !wr_stb && !bus_oe));

    a_r4_io_needs_aen_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_stb || wr_stb) && !acc_mem) |-> !$past(aen));

    a_r7_mem_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_stb || wr_stb) && acc_mem) |-> $past(mem_en));

    a_r8_io_read_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !acc_mem) |=> !(rd_stb && !acc_mem));

    a_r8_mem_write_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && acc_mem) |=> !(wr_stb && acc_mem));

    a_r9_oe_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> rd_stb);

    a_r11_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb));

endmodule

bind isa_slave_decoder isa_slave_decoder_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .aen     (aen),
    .mem_en  (mem_en),
    .rd_stb  (rd_stb),
    .wr_stb  (wr_stb),
    .acc_mem (acc_mem),
    .bus_oe  (bus_oe)
);

// File: tb/test_isa_slave_decoder.sv
`timescale 1ns/1ps
module test_isa_slave_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sa = '0;
    logic [11:0] mem_hi = '0;
    logic        aen = 1'b0;
    logic        ior_n = 1'b1, iow_n = 1'b1, memr_n = 1'b1, memw_n = 1'b1;
    logic [11:0] io_base = 12'h030;
    logic [11:0] mem_base = 12'h0D0;
    logic        mem_en = 1'b0;
    logic        rd_stb, wr_stb, acc_mem, byte_hi, bus_oe;
    logic [10:0] word_off;

    always #2.5 clk = ~clk;

    isa_slave_decoder i_isa_slave_decoder (
        .clk(clk), .rst_n(rst_n), .sa(sa), .mem_hi(mem_hi), .aen(aen),
        .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n),
        .io_base(io_base), .mem_base(mem_base), .mem_en(mem_en),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .acc_mem(acc_mem),
        .byte_hi(byte_hi), .word_off(word_off), .bus_oe(bus_oe)
    );

    int    checks = 0;
    int    failures = 0;
    string cur_req = "R1";
    bit    done = 1'b0;
    int    cycles = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference model: history of sampled commands, bit0 ior, bit1 iow, bit2 memr, bit3 memw
    logic [3:0] hist [$];
    bit         e_rd, e_wr, e_mem, e_byte, e_oe, e_oe_mem;
    int         e_off;

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = {4'hF, 4'hF, 4'hF};
            e_rd = 0; e_wr = 0; e_mem = 0; e_byte = 0; e_oe = 0; e_oe_mem = 0; e_off = 0;
        end else begin
            logic [3:0] started;
            bit io_ok, mem_ok, t0, t1, t2, t3, hold;
            started = hist[2] & ~hist[1];
            io_ok  = !aen && (sa[15:4] == io_base);
            mem_ok = mem_en && (mem_hi == mem_base);
            t0 = started[0] && io_ok;
            t1 = started[1] && io_ok && !t0;
            t2 = started[2] && mem_ok && !t0 && !t1;
            t3 = started[3] && mem_ok && !t0 && !t1 && !t2;
            hold = e_oe_mem ? !hist[1][2] : !hist[1][0];
            e_rd = t0 || t2;
            e_wr = t1 || t3;
            if (t0 || t1) begin e_mem = 0; e_byte = sa[0]; e_off = int'(sa[3:1]); end
            else if (t2 || t3) begin e_mem = 1; e_byte = sa[0]; e_off = int'(sa[11:1]); end
            if (t0 || t2) begin e_oe = 1; e_oe_mem = t2; end
            else if (e_oe && !hold) e_oe = 0;
            hist.push_front({memw_n, memr_n, iow_n, ior_n});
            void'(hist.pop_back());
        end
    end

    int rd_cnt, wr_cnt, oe_cnt, both_cnt;
    always @(negedge clk) begin
        cycles++;
        if (rst_n && !done) begin
            check(rd_stb == e_rd, cur_req, "rd_stb", rd_stb, e_rd);
            check(wr_stb == e_wr, cur_req, "wr_stb", wr_stb, e_wr);
            check(bus_oe == e_oe, cur_req, "bus_oe", bus_oe, e_oe);
            check(acc_mem == e_mem && byte_hi == e_byte && int'(word_off) == e_off,
                  cur_req, "offset", {acc_mem, byte_hi, word_off}, {e_mem, e_byte, e_off[10:0]});
            if (rd_stb) rd_cnt++;
            if (wr_stb) wr_cnt++;
            if (bus_oe) oe_cnt++;
            if (rd_stb && wr_stb) both_cnt++;
        end
    end

    task automatic access(input logic [3:0] low_mask, input logic [15:0] a,
                          input logic [11:0] hi, input bit aen_v, input int hold);
        @(negedge clk); #1;
        rd_cnt = 0; wr_cnt = 0; oe_cnt = 0; both_cnt = 0;
        sa = a; mem_hi = hi; aen = aen_v;
        ior_n = !low_mask[0]; iow_n = !low_mask[1];
        memr_n = !low_mask[2]; memw_n = !low_mask[3];
        repeat (hold) @(negedge clk);
        #1;
        ior_n = 1; iow_n = 1; memr_n = 1; memw_n = 1;
        repeat (6) @(negedge clk);
        #1;
        aen = 0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(negedge clk) begin
        if (cycles > 5000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 5000);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        cur_req = "R1";
        check(!rd_stb && !wr_stb && !bus_oe && !acc_mem && !byte_hi && word_off == 0,
              "R1", "reset outputs", {rd_stb, wr_stb, bus_oe, acc_mem, byte_hi}, 0);
        #1 rst_n = 1;
        repeat (3) @(negedge clk);

        cur_req = "R2";
        access(4'b0001, 16'h0306, 12'h000, 0, 4);
        check(rd_cnt == 1 && wr_cnt == 0, "R2", "io read pulses", rd_cnt, 1);
        check(word_off == 3 && !byte_hi && !acc_mem, "R2", "io read offset", word_off, 3);
        access(4'b0001, 16'h0309, 12'h000, 0, 3);
        check(word_off == 4 && byte_hi, "R2", "io read odd byte", {byte_hi, word_off}, 12'h804);

        cur_req = "R3";
        access(4'b0010, 16'h030F, 12'h000, 0, 4);
        check(wr_cnt == 1 && rd_cnt == 0 && word_off == 7, "R3", "io write", {wr_cnt, word_off}, 7);

        cur_req = "R4";
        access(4'b0001, 16'h0306, 12'h000, 1, 4);
        check(rd_cnt == 0, "R4", "read with aen high", rd_cnt, 0);
        access(4'b0010, 16'h0306, 12'h000, 1, 4);
        check(wr_cnt == 0, "R4", "write with aen high", wr_cnt, 0);

        cur_req = "R5";
        access(4'b0001, 16'h0310, 12'h000, 0, 4);
        check(rd_cnt == 0, "R5", "above window", rd_cnt, 0);
        access(4'b0010, 16'h02FF, 12'h000, 0, 4);
        check(wr_cnt == 0, "R5", "below window", wr_cnt, 0);

        cur_req = "R7";
        access(4'b0100, 16'h0ABC, 12'h0D0, 0, 4);
        check(rd_cnt == 0, "R7", "memory read while disabled", rd_cnt, 0);
        access(4'b0001, 16'h0302, 12'h000, 0, 3);
        check(rd_cnt == 1 && word_off == 1, "R7", "io with memory disabled", rd_cnt, 1);

        cur_req = "R6";
        mem_en = 1;
        access(4'b0100, 16'h0ABC, 12'h0D0, 0, 4);
        check(rd_cnt == 1 && acc_mem && word_off == 11'h55E && !byte_hi, "R6", "memory read",
              word_off, 11'h55E);
        access(4'b1000, 16'h0001, 12'h0D0, 1, 4);
        check(wr_cnt == 1 && acc_mem && word_off == 0 && byte_hi, "R6", "memory write, aen high",
              wr_cnt, 1);
        access(4'b0100, 16'h0ABC, 12'h0D1, 0, 4);
        check(rd_cnt == 0, "R6", "memory miss", rd_cnt, 0);

        cur_req = "R8";
        access(4'b0001, 16'h0304, 12'h000, 0, 40);
        check(rd_cnt == 1, "R8", "long hold", rd_cnt, 1);
        access(4'b1000, 16'h0010, 12'h0D0, 0, 25);
        check(wr_cnt == 1, "R8", "long memory write", wr_cnt, 1);

        cur_req = "R9";
        access(4'b0001, 16'h0300, 12'h000, 0, 10);
        check(oe_cnt == 10, "R9", "oe length io read", oe_cnt, 10);
        access(4'b0010, 16'h0300, 12'h000, 0, 10);
        check(oe_cnt == 0, "R9", "oe on write", oe_cnt, 0);
        access(4'b0001, 16'h0400, 12'h000, 0, 10);
        check(oe_cnt == 0, "R9", "oe on miss", oe_cnt, 0);
        access(4'b0100, 16'h0020, 12'h0D0, 0, 7);
        check(oe_cnt == 7, "R9", "oe length memory read", oe_cnt, 7);

        cur_req = "R10";
        access(4'b0101, 16'h0306, 12'h0D0, 0, 5);
        check(rd_cnt == 1 && !acc_mem && word_off == 3, "R10", "io read over memory read",
              acc_mem, 0);
        access(4'b1010, 16'h0306, 12'h0D0, 0, 5);
        check(wr_cnt == 1 && !acc_mem, "R10", "io write over memory write", acc_mem, 0);
        access(4'b1100, 16'h0042, 12'h0D0, 0, 5);
        check(rd_cnt == 1 && wr_cnt == 0 && acc_mem, "R10", "memory read over memory write",
              {rd_cnt, wr_cnt}, 1 << 0);

        cur_req = "R11";
        access(4'b0011, 16'h0308, 12'h000, 0, 5);
        check(rd_cnt == 1 && wr_cnt == 0 && both_cnt == 0, "R11", "read and write together",
              both_cnt, 0);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule